// File: doc/BRIEF.md
# DDS Frequency Source Arbiter

This block decides which 32-bit frequency tuning word feeds the phase accumulator of a direct digital synthesizer. Four candidates compete under a fixed priority: a waveform-RAM playback word, a digital ramp generator word, a parallel-port word that is shifted and added to an offset, and the frequency word of the active profile. A candidate competes only when its enable is set and its destination code selects frequency. The winner's tuning word is registered together with the phase and amplitude words of the active profile, and a code naming the winning source is registered beside it.

The block holds two banks of profile registers, each with eight profiles. One bank holds the single-tone settings and the other holds the RAM-mode settings. The RAM enable picks which bank is live, so toggling it switches every profile at once. Single-tone writes made while RAM mode is on go into the tone bank, which is hidden at that time, and they take effect on the output only when RAM mode ends. Exactly one profile is active. A profile can be activated directly. Deactivating the active profile hands control to the next profile in ascending order.

Every output is a level that holds its value. There is no stream and no handshake: the consumer samples the outputs on each clock.

Top module: `dds_freq_arbiter`

## Requirements
- R1: Priority from highest to lowest is RAM, ramp, parallel, tone. `src_out` names the winner: 3 is RAM, 2 is ramp, 1 is parallel, 0 is tone.
- R2: A source competes only when its enable is 1 and its destination code is 0 (frequency). The codes 1 (phase), 2 (amplitude) and 3 (polar) take the source out of the frequency choice.
- R3: The parallel word equals `par_offset + (par_data << par_shift)`. `par_data` is zero-extended, `par_shift` ranges from 0 to 15, and the sum wraps modulo 2^32.
- R4: When no source competes, `ftw_out` is the frequency word of the active profile in the live bank. `pow_out` and `asf_out` always come from the active profile in the live bank.
- R5: Reset clears every output, both banks, and `active_prof`, which returns to profile 0.
- R6: A pulse on `prof_on` makes profile `prof_idx` active on the next clock edge. If `prof_on` and `prof_off` are both high in the same cycle, `prof_on` takes precedence.
- R7: A pulse on `prof_off` with `prof_idx` equal to the active profile activates the next profile in ascending order, so profile 7 wraps to profile 0. A `prof_off` that names any other profile is ignored.
- R8: A write stores the low bits of `wr_data` into one field of one profile. `wr_fld` selects the field: 0 is frequency, 1 is phase (16 bits), 2 is amplitude (14 bits). A write with field code 3 changes nothing. When `wr_ram` is 0, the write goes to the tone bank, so a tone write made while RAM mode is on leaves the outputs unchanged.
- R9: When `ram_en` is 1, the RAM bank is live. When `ram_en` is 0, the tone bank is live. A `wr_ram` value of 1 writes the RAM bank. Turning RAM mode off makes the tone values written during RAM mode appear on the outputs.
- R10: The outputs are registered. A change at a source input appears one clock edge later. A change to a bank or to the active profile appears one edge after the edge that stored it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Profile write strobe |
| wr_ram | input | 1 | Write target: 1 is the RAM bank, 0 is the tone bank |
| wr_prof | input | 3 | Profile index for the write |
| wr_fld | input | 2 | Field code for the write |
| wr_data | input | 32 | Write data, low-aligned |
| prof_on | input | 1 | Activate profile `prof_idx` |
| prof_off | input | 1 | Deactivate profile `prof_idx` |
| prof_idx | input | 3 | Profile index for activate or deactivate |
| ram_en | input | 1 | RAM mode enable, also selects the live bank |
| ram_dest | input | 2 | RAM destination code |
| ram_ftw | input | 32 | RAM playback tuning word |
| drg_en | input | 1 | Ramp generator enable |
| drg_dest | input | 2 | Ramp destination code |
| drg_ftw | input | 32 | Ramp tuning word |
| par_en | input | 1 | Parallel port enable |
| par_dest | input | 2 | Parallel destination code |
| par_data | input | 16 | Parallel data word |
| par_shift | input | 4 | Left shift applied to the parallel data |
| par_offset | input | 32 | Offset added to the shifted parallel data |
| ftw_out | output | 32 | Selected tuning word |
| pow_out | output | 16 | Phase word of the active profile |
| asf_out | output | 14 | Amplitude word of the active profile |
| src_out | output | 2 | Code of the winning source |
| active_prof | output | 3 | Index of the active profile |

## Verification
The bench builds the block with its default parameters: eight profiles, a 32-bit tuning word, a 16-bit parallel word and a 4-bit shift. With these values the wrap from profile 7 to profile 0 can be reached. So can a full 15-bit shift into the top of the word and an offset-plus-data carry that wraps past 2^32. Keeping both banks at eight entries lets one profile carry different values in each bank. The bench uses that to show the bank swap and the hidden tone writes on `ftw_out` and `pow_out`.

// File: rtl/dds_arb_pkg.sv
package dds_arb_pkg;
  typedef enum logic [1:0] {
    DST_FREQ  = 2'd0,
    DST_PHASE = 2'd1,
    DST_AMPL  = 2'd2,
    DST_POLAR = 2'd3
  } dst_e;

  typedef enum logic [1:0] {
    SRC_TONE = 2'd0,
    SRC_PAR  = 2'd1,
    SRC_DRG  = 2'd2,
    SRC_RAM  = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    FLD_FREQ  = 2'd0,
    FLD_PHASE = 2'd1,
    FLD_AMPL  = 2'd2,
    FLD_NONE  = 2'd3
  } fld_e;
endpackage

// File: rtl/dds_prof_bank.sv
module dds_prof_bank #(
  parameter int PROF_N = 8,
  parameter int FTW_W  = 32,
  parameter int POW_W  = 16,
  parameter int ASF_W  = 14,
  localparam int IW    = $clog2(PROF_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_ram,
  input  logic [IW-1:0]    wr_idx,
  input  logic [1:0]       wr_fld,
  input  logic [FTW_W-1:0] wr_data,
  input  logic             ram_mode,
  input  logic [IW-1:0]    rd_idx,
  output logic [FTW_W-1:0] rd_frq,
  output logic [POW_W-1:0] rd_pow,
  output logic [ASF_W-1:0] rd_asf
);
  import dds_arb_pkg::*;

  // bank 0 holds tone settings, bank 1 holds RAM-mode settings
  logic [FTW_W-1:0] frq_q [2][PROF_N];
  logic [POW_W-1:0] pow_q [2][PROF_N];
  logic [ASF_W-1:0] asf_q [2][PROF_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++) begin
        for (int p = 0; p < PROF_N; p++) begin
          frq_q[b][p] <= '0;
          pow_q[b][p] <= '0;
          asf_q[b][p] <= '0;
        end
      end
    end else if (wr_en) begin
      case (fld_e'(wr_fld))
        FLD_FREQ:  frq_q[wr_ram][wr_idx] <= wr_data;
        FLD_PHASE: pow_q[wr_ram][wr_idx] <= wr_data[POW_W-1:0];
        FLD_AMPL:  asf_q[wr_ram][wr_idx] <= wr_data[ASF_W-1:0];
        default:   ;
      endcase
    end
  end

  always_comb begin
    rd_frq = frq_q[ram_mode][rd_idx];
    rd_pow = pow_q[ram_mode][rd_idx];
    rd_asf = asf_q[ram_mode][rd_idx];
  end
endmodule

// File: rtl/dds_prof_ctrl.sv
module dds_prof_ctrl #(
  parameter int PROF_N = 8,
  localparam int IW    = $clog2(PROF_N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prof_on,
  input  logic          prof_off,
  input  logic [IW-1:0] prof_idx,
  output logic [IW-1:0] active
);
  localparam logic [IW-1:0] LAST = IW'(PROF_N - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= '0;
    end else if (prof_on) begin
      active <= prof_idx;
    end else if (prof_off && (prof_idx == active)) begin
      active <= (active == LAST) ? '0 : active + 1'b1;
    end
  end
endmodule

// File: rtl/dds_src_select.sv
module dds_src_select #(
  parameter int FTW_W = 32,
  parameter int PAR_W = 16,
  parameter int SH_W  = 4
) (
  input  logic             ram_en,
  input  logic [1:0]       ram_dest,
  input  logic [FTW_W-1:0] ram_ftw,
  input  logic             drg_en,
  input  logic [1:0]       drg_dest,
  input  logic [FTW_W-1:0] drg_ftw,
  input  logic             par_en,
  input  logic [1:0]       par_dest,
  input  logic [PAR_W-1:0] par_data,
  input  logic [SH_W-1:0]  par_shift,
  input  logic [FTW_W-1:0] par_offset,
  input  logic [FTW_W-1:0] tone_ftw,
  output logic [FTW_W-1:0] ftw_nxt,
  output logic [1:0]       src_nxt
);
  import dds_arb_pkg::*;

  logic             ram_hit, drg_hit, par_hit;
  logic [FTW_W-1:0] par_word;

  assign ram_hit  = ram_en && (dst_e'(ram_dest) == DST_FREQ);
  assign drg_hit  = drg_en && (dst_e'(drg_dest) == DST_FREQ);
  assign par_hit  = par_en && (dst_e'(par_dest) == DST_FREQ);
  assign par_word = par_offset + (FTW_W'(par_data) << par_shift);

  always_comb begin
    if (ram_hit) begin
      ftw_nxt = ram_ftw;
      src_nxt = SRC_RAM;
    end else if (drg_hit) begin
      ftw_nxt = drg_ftw;
      src_nxt = SRC_DRG;
    end else if (par_hit) begin
      ftw_nxt = par_word;
      src_nxt = SRC_PAR;
    end else begin
      ftw_nxt = tone_ftw;
      src_nxt = SRC_TONE;
    end
  end
endmodule

// File: rtl/dds_freq_arbiter.sv
module dds_freq_arbiter #(
  parameter int PROF_N = 8,
  parameter int FTW_W  = 32,
  parameter int POW_W  = 16,
  parameter int ASF_W  = 14,
  parameter int PAR_W  = 16,
  parameter int SH_W   = 4,
  localparam int IW    = $clog2(PROF_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_ram,
  input  logic [IW-1:0]    wr_prof,
  input  logic [1:0]       wr_fld,
  input  logic [FTW_W-1:0] wr_data,
  input  logic             prof_on,
  input  logic             prof_off,
  input  logic [IW-1:0]    prof_idx,
  input  logic             ram_en,
  input  logic [1:0]       ram_dest,
  input  logic [FTW_W-1:0] ram_ftw,
  input  logic             drg_en,
  input  logic [1:0]       drg_dest,
  input  logic [FTW_W-1:0] drg_ftw,
  input  logic             par_en,
  input  logic [1:0]       par_dest,
  input  logic [PAR_W-1:0] par_data,
  input  logic [SH_W-1:0]  par_shift,
  input  logic [FTW_W-1:0] par_offset,
  output logic [FTW_W-1:0] ftw_out,
  output logic [POW_W-1:0] pow_out,
  output logic [ASF_W-1:0] asf_out,
  output logic [1:0]       src_out,
  output logic [IW-1:0]    active_prof
);
  logic [FTW_W-1:0] live_frq, ftw_nxt;
  logic [POW_W-1:0] live_pow;
  logic [ASF_W-1:0] live_asf;
  logic [1:0]       src_nxt;

  dds_prof_ctrl #(.PROF_N(PROF_N)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .prof_on(prof_on), .prof_off(prof_off),
    .prof_idx(prof_idx), .active(active_prof)
  );

  dds_prof_bank #(.PROF_N(PROF_N), .FTW_W(FTW_W), .POW_W(POW_W), .ASF_W(ASF_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ram(wr_ram), .wr_idx(wr_prof),
    .wr_fld(wr_fld), .wr_data(wr_data), .ram_mode(ram_en), .rd_idx(active_prof),
    .rd_frq(live_frq), .rd_pow(live_pow), .rd_asf(live_asf)
  );

  dds_src_select #(.FTW_W(FTW_W), .PAR_W(PAR_W), .SH_W(SH_W)) u_sel (
    .ram_en(ram_en), .ram_dest(ram_dest), .ram_ftw(ram_ftw),
    .drg_en(drg_en), .drg_dest(drg_dest), .drg_ftw(drg_ftw),
    .par_en(par_en), .par_dest(par_dest), .par_data(par_data),
    .par_shift(par_shift), .par_offset(par_offset), .tone_ftw(live_frq),
    .ftw_nxt(ftw_nxt), .src_nxt(src_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ftw_out <= '0;
      pow_out <= '0;
      asf_out <= '0;
      src_out <= '0;
    end else begin
      ftw_out <= ftw_nxt;
      pow_out <= live_pow;
      asf_out <= live_asf;
      src_out <= src_nxt;
    end
  end
endmodule

// File: rtl/dds_arb_chk.sv
module dds_arb_chk #(
  parameter int PROF_N = 8,
  parameter int FTW_W  = 32,
  parameter int PAR_W  = 16,
  parameter int SH_W   = 4,
  localparam int IW    = $clog2(PROF_N)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             prof_on,
  input logic             prof_off,
  input logic [IW-1:0]    prof_idx,
  input logic             ram_en,
  input logic [1:0]       ram_dest,
  input logic [FTW_W-1:0] ram_ftw,
  input logic             drg_en,
  input logic [1:0]       drg_dest,
  input logic [FTW_W-1:0] drg_ftw,
  input logic             par_en,
  input logic [1:0]       par_dest,
  input logic [PAR_W-1:0] par_data,
  input logic [SH_W-1:0]  par_shift,
  input logic [FTW_W-1:0] par_offset,
  input logic [FTW_W-1:0] ftw_out,
  input logic [1:0]       src_out,
  input logic [IW-1:0]    active_prof
);
  logic ram_f, drg_f, par_f;
  assign ram_f = ram_en && (ram_dest == 2'd0);
  assign drg_f = drg_en && (drg_dest == 2'd0);
  assign par_f = par_en && (par_dest == 2'd0);

  // R1
  ram_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_f |=> (ftw_out == $past(ram_ftw)) && (src_out == 2'd3));
  // R2
  drg_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_f && drg_f) |=> (ftw_out == $past(drg_ftw)) && (src_out == 2'd2));
  // R3
  par_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_f && !drg_f && par_f) |=>
      ftw_out == $past(par_offset + (FTW_W'(par_data) << par_shift)));
  // R6
  prof_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prof_on |=> active_prof == $past(prof_idx));
  // R7
  prof_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!prof_on && prof_off && prof_idx == active_prof) |=>
      active_prof == (($past(active_prof) == IW'(PROF_N - 1)) ? '0 : $past(active_prof) + 1'b1));
  // R7
  prof_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!prof_on && !(prof_off && prof_idx == active_prof)) |=> $stable(active_prof));
endmodule

bind dds_freq_arbiter dds_arb_chk #(
  .PROF_N(PROF_N), .FTW_W(FTW_W), .PAR_W(PAR_W), .SH_W(SH_W)
) u_chk (.*);

// File: tb/test_dds_freq_arbiter.sv
module test_dds_freq_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_ram = 1'b0;
  logic [2:0]  wr_prof = '0;
  logic [1:0]  wr_fld = '0;
  logic [31:0] wr_data = '0;
  logic        prof_on = 1'b0, prof_off = 1'b0;
  logic [2:0]  prof_idx = '0;
  logic        ram_en = 1'b0, drg_en = 1'b0, par_en = 1'b0;
  logic [1:0]  ram_dest = '0, drg_dest = '0, par_dest = '0;
  logic [31:0] ram_ftw = '0, drg_ftw = '0, par_offset = '0;
  logic [15:0] par_data = '0;
  logic [3:0]  par_shift = '0;
  logic [31:0] ftw_out;
  logic [15:0] pow_out;
  logic [13:0] asf_out;
  logic [1:0]  src_out;
  logic [2:0]  active_prof;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dds_freq_arbiter i_dds_freq_arbiter (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic bank, input logic [2:0] p, input logic [1:0] f, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_ram = bank; wr_prof = p; wr_fld = f; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic prof_op(input logic on, input logic [2:0] p);
    @(negedge clk);
    prof_on = on; prof_off = !on; prof_idx = p;
    @(negedge clk);
    prof_on = 1'b0; prof_off = 1'b0;
  endtask

  task automatic t_reset();
    chk("R5 ftw", ftw_out, 32'h0);
    chk("R5 pow", 32'(pow_out), 32'h0);
    chk("R5 asf", 32'(asf_out), 32'h0);
    chk("R5 active", 32'(active_prof), 32'h0);
    chk("R5 src", 32'(src_out), 32'h0);
  endtask

  task automatic t_tone();
    wr(1'b0, 3'd3, 2'd0, 32'h1234_5678);
    wr(1'b0, 3'd3, 2'd1, 32'h0000_ABCD);
    wr(1'b0, 3'd3, 2'd2, 32'hFFFF_FFFF);
    prof_op(1'b1, 3'd3);
    chk("R6 active", 32'(active_prof), 32'd3);
    @(negedge clk);
    chk("R4 tone ftw", ftw_out, 32'h1234_5678);
    chk("R8 phase", 32'(pow_out), 32'h0000_ABCD);
    chk("R8 amp 14 bits", 32'(asf_out), 32'h0000_3FFF);
    wr(1'b0, 3'd3, 2'd3, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R8 field3 ftw", ftw_out, 32'h1234_5678);
    chk("R8 field3 pow", 32'(pow_out), 32'h0000_ABCD);
  endtask

  task automatic t_profile();
    prof_op(1'b1, 3'd7);
    chk("R6 to 7", 32'(active_prof), 32'd7);
    prof_op(1'b0, 3'd7);
    chk("R7 wrap", 32'(active_prof), 32'd0);
    prof_op(1'b0, 3'd5);
    chk("R7 non-active off", 32'(active_prof), 32'd0);
    prof_op(1'b0, 3'd0);
    chk("R7 next", 32'(active_prof), 32'd1);
    @(negedge clk);
    prof_on = 1'b1; prof_off = 1'b1; prof_idx = 3'd3;
    @(negedge clk);
    prof_on = 1'b0; prof_off = 1'b0;
    chk("R6 on wins", 32'(active_prof), 32'd3);
  endtask

  task automatic t_priority();
    wr(1'b1, 3'd3, 2'd0, 32'hCAFE_0000);
    wr(1'b1, 3'd3, 2'd1, 32'h0000_1111);
    @(negedge clk);
    par_en = 1'b1; par_dest = 2'd0; par_data = 16'h0010; par_shift = 4'd4; par_offset = 32'h1000_0000;
    @(negedge clk);
    chk("R3 par", ftw_out, 32'h1000_0100);
    chk("R1 src par", 32'(src_out), 32'd1);
    drg_en = 1'b1; drg_dest = 2'd0; drg_ftw = 32'h2222_2222;
    @(negedge clk);
    chk("R1 drg over par", ftw_out, 32'h2222_2222);
    chk("R1 src drg", 32'(src_out), 32'd2);
    ram_en = 1'b1; ram_dest = 2'd0; ram_ftw = 32'h3333_3333;
    @(negedge clk);
    chk("R1 ram over all", ftw_out, 32'h3333_3333);
    chk("R1 src ram", 32'(src_out), 32'd3);
    chk("R9 ram bank pow", 32'(pow_out), 32'h0000_1111);
    ram_dest = 2'd1;
    @(negedge clk);
    chk("R2 ram phase dest", ftw_out, 32'h2222_2222);
    drg_dest = 2'd2;
    @(negedge clk);
    chk("R2 drg amp dest", ftw_out, 32'h1000_0100);
    par_dest = 2'd3;
    @(negedge clk);
    chk("R4 fallback ram bank", ftw_out, 32'hCAFE_0000);
    chk("R4 src tone", 32'(src_out), 32'd0);
    par_en = 1'b0; par_dest = 2'd0;
    @(negedge clk);
    chk("R2 par disabled", ftw_out, 32'hCAFE_0000);
  endtask

  task automatic t_shadow();
    wr(1'b0, 3'd3, 2'd0, 32'h0BAD_F00D);
    @(negedge clk);
    chk("R8 hidden tone write", ftw_out, 32'hCAFE_0000);
    ram_en = 1'b0;
    @(negedge clk);
    chk("R9 tone bank live", ftw_out, 32'h0BAD_F00D);
    chk("R9 tone pow", 32'(pow_out), 32'h0000_ABCD);
  endtask

  task automatic t_par();
    @(negedge clk);
    drg_en = 1'b0; ram_en = 1'b0;
    par_en = 1'b1; par_dest = 2'd0; par_data = 16'h0020; par_shift = 4'd0; par_offset = 32'hFFFF_FFF0;
    @(negedge clk);
    chk("R3 wrap", ftw_out, 32'h0000_0010);
    par_data = 16'hFFFF; par_shift = 4'd15; par_offset = 32'h0;
    @(negedge clk);
    chk("R3 shift 15", ftw_out, 32'h7FFF_8000);
  endtask

  task automatic t_latency();
    @(negedge clk);
    drg_en = 1'b1; drg_dest = 2'd0; drg_ftw = 32'h55AA_55AA;
    #1;
    chk("R10 before edge", ftw_out, 32'h7FFF_8000);
    @(negedge clk);
    chk("R10 after edge", ftw_out, 32'h55AA_55AA);
    drg_en = 1'b0; par_en = 1'b0;
    @(negedge clk);
    wr_en = 1'b1; wr_ram = 1'b0; wr_prof = 3'd3; wr_fld = 2'd0; wr_data = 32'h0F0F_0F0F;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R10 bank not yet", ftw_out, 32'h0BAD_F00D);
    @(negedge clk);
    chk("R10 bank visible", ftw_out, 32'h0F0F_0F0F);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tone();
    t_profile();
    t_priority();
    t_shadow();
    t_par();
    t_latency();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule